// File: doc/BRIEF.md
# Infrared Receive Sampler with Optional Demodulation

This block turns an active-low infrared line into bytes. Once it is enabled, it watches the line for the first sign of traffic. In raw mode that sign is a low level. In demodulating mode it is a pair of close carrier edges. When it sees that sign it raises an activity flag and starts a bit timer. Each bit-time yields one sample. Eight samples, with the earliest one in the least significant position, make a byte. That byte goes into a 16-entry receive FIFO.

Software drives the block through a small byte-wide register port. Through that port it sets the bit-time divisor and the carrier gap setting, which are the same values the transmitter uses. It also selects raw or demodulated sampling, pops received bytes and reads the status. Writing 1 to the activity flag ends a reception. The next detection then starts packing again from bit 0.

Top module: `irRxSampler`

## Requirements
- R1: While the enable bit (control register, address 1, bit 0) is 0, the activity flag never sets and no byte enters the FIFO. Clearing the enable bit drops an active reception on the next clock.
- R2: Raw mode (control bit 1 = 0): the line passes through two synchronizing flops. It is sampled once per bit-time, at phase divisor/2, and a low level is stored as 0.
- R3: Demodulated mode (control bit 1 = 1): a bit is stored as 0 when its window holds a falling edge that comes no later than the gap limit after the previous falling edge. Otherwise the bit is stored as 1.
- R4: One bit-time lasts divisor+1 clocks. The 16-bit divisor is written low byte at address 2 and high byte at address 3, and both bytes read back.
- R5: The gap limit is (code+1) clocks when the range bit is 1 and 8×(code+1) clocks when it is 0. The code is bits 4:0 and the range bit is bit 5 of address 4. Carrier with a longer edge spacing is not detected.
- R6: While the block is enabled and idle, detection sets the activity flag (control bit 2). In raw mode detection is a synchronized low level; in demodulated mode it is a qualifying edge pair. Sampling then runs until the flag is cleared.
- R7: Writing 1 to control bit 2 clears the activity flag and discards the partial byte. The next detection restarts packing at bit 0.
- R8: Samples are packed least significant bit first, and a byte is pushed after every 8th sample.
- R9: The FIFO holds 16 bytes. A read of address 0 returns the oldest byte and pops it, and returns 0 when the FIFO is empty. Status (address 5) gives bit 0 = not empty, bit 1 = full and bits 7:3 = count.
- R10: A byte completed while the FIFO is full is dropped and sets status bit 2. That bit stays set until 1 is written to it.
- R11: After reset, the control, divisor, carrier and status registers read 0, and a data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irInN | input | 1 | Active-low infrared line, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops FIFO at address 0) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |

## Verification
The hardest state to reach is the demodulated bit decision. Detection happens on the second carrier edge, so every later window is offset from the bit slots by the sync latency plus one carrier period. The bench therefore puts each slot's carrier burst in the middle of the slot. Only the first slot gets an extra leading edge pair to trigger detection, so no burst straddles a window boundary. A separate run uses a tight gap limit and shows that the same carrier is then never detected. Overrun is reached by holding the line low in raw mode with a short bit-time until more than 16 bytes have been completed.

// File: rtl/irRxPkg.sv
package irRxPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // new reception detected: clear packing state
    logic takeBit;  // store one sample now
    logic endWin;   // current bit window closes this cycle
    logic demod;    // demodulated sampling selected
    logic running;  // activity flag
    logic popReq;   // data register read
    logic clrOvr;   // write-one-clear of overrun
  } rxStrobes_t;
endpackage

// File: rtl/irRxCtrl.sv
module irRxCtrl
  import irRxPkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int CODE_W = 5,
  parameter int GAP_W  = 10,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             rawLvl,
  input  logic             carrierEvt,
  input  logic [7:0]       fifoHead,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             overrun,
  output logic [GAP_W-1:0] gapLimit,
  output rxStrobes_t       stb
);
  localparam int HALF_SHIFT = 1;

  logic             ctrlEn, ctrlDemod, rxActive;
  logic [DIV_W-1:0] divReg, phase;
  logic [7:0]       carrReg;
  logic             stopWr, detect, endWin, midHit;

  assign stopWr = regWrEn && regAddr == 3'd1 && regWrData[2];
  assign detect = ctrlEn && !rxActive && (ctrlDemod ? carrierEvt : !rawLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ctrlDemod <= 1'b0; divReg <= '0; carrReg <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        3'd1: begin ctrlEn <= regWrData[0]; ctrlDemod <= regWrData[1]; end
        3'd2: divReg[7:0] <= regWrData;
        3'd3: divReg[DIV_W-1:8] <= regWrData[DIV_W-9:0];
        3'd4: carrReg <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxActive <= 1'b0;
    else if (!ctrlEn || stopWr) rxActive <= 1'b0;
    else if (detect) rxActive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (detect) phase <= '0;
    else if (rxActive) phase <= (phase == divReg) ? '0 : phase + 1'b1;
  end

  assign endWin = rxActive && phase == divReg;
  assign midHit = rxActive && phase == (divReg >> HALF_SHIFT);

  always_comb begin
    logic [GAP_W-1:0] base;
    base     = GAP_W'(carrReg[CODE_W-1:0]) + 1'b1;
    gapLimit = carrReg[CODE_W] ? base : (base << 3);
  end

  always_comb begin
    stb.restart = detect;
    stb.endWin  = endWin;
    stb.takeBit = ctrlDemod ? endWin : midHit;
    stb.demod   = ctrlDemod;
    stb.running = rxActive;
    stb.popReq  = regRdEn && regAddr == 3'd0;
    stb.clrOvr  = regWrEn && regAddr == 3'd5 && regWrData[2];
  end

  always_comb begin
    case (regAddr)
      3'd0: regRdData = fifoHead;
      3'd1: regRdData = {5'd0, rxActive, ctrlDemod, ctrlEn};
      3'd2: regRdData = divReg[7:0];
      3'd3: regRdData = divReg[DIV_W-1:8];
      3'd4: regRdData = carrReg;
      3'd5: regRdData = 8'({fifoCount, overrun, fifoFull, ~fifoEmpty});
      default: regRdData = 8'd0;
    endcase
  end

  // R1: no activity while disabled
  p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> !rxActive);
  // R7: a stop write always ends reception
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !rxActive);
  // R6: flag rises only while enabled
  p_rise_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxActive) |-> $past(ctrlEn));
endmodule

// File: rtl/irRxDatapath.sv
module irRxDatapath
  import irRxPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GAP_W = 10,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irInN,
  input  rxStrobes_t       stb,
  input  logic [GAP_W-1:0] gapLimit,
  output logic             rawLvl,
  output logic             carrierEvt,
  output logic [BITS-1:0]  fifoHead,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             overrun
);
  localparam int AW    = $clog2(DEPTH);
  localparam int BCW   = $clog2(BITS);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic irMeta, irSync, irPrev, fallEdge, edgeSeen, winHit, bitVal, pushReq;
  logic [GAP_W-1:0] gapCnt;
  logic [BITS-1:0]  shiftReg, pushByte;
  logic [BCW-1:0]   bitCnt;
  logic [BITS-1:0]  mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin irMeta <= 1'b1; irSync <= 1'b1; irPrev <= 1'b1; end
    else begin irMeta <= irInN; irSync <= irMeta; irPrev <= irSync; end
  end
  assign rawLvl   = irSync;
  assign fallEdge = irPrev && !irSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin gapCnt <= GAP_MAX; edgeSeen <= 1'b0; end
    else if (fallEdge) begin gapCnt <= GAP_W'(1); edgeSeen <= 1'b1; end
    else if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end
  assign carrierEvt = fallEdge && edgeSeen && gapCnt <= gapLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winHit <= 1'b0;
    else if (stb.restart) winHit <= 1'b1;
    else if (stb.endWin) winHit <= 1'b0;
    else if (carrierEvt) winHit <= 1'b1;
  end

  assign bitVal   = stb.demod ? !(winHit || carrierEvt) : irSync;
  assign pushByte = {bitVal, shiftReg[BITS-1:1]};
  assign pushReq  = stb.takeBit && bitCnt == BCW'(BITS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin shiftReg <= '0; bitCnt <= '0; end
    else if (stb.restart) begin shiftReg <= '0; bitCnt <= '0; end
    else if (stb.takeBit) begin shiftReg <= pushByte; bitCnt <= bitCnt + 1'b1; end
  end

  assign fifoEmpty = fifoCount == '0;
  assign fifoFull  = fifoCount == (AW+1)'(DEPTH);
  assign doPush    = pushReq && !fifoFull;
  assign doPop     = stb.popReq && !fifoEmpty;
  assign fifoHead  = fifoEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) if (doPush) mem[wrPtr] <= pushByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin wrPtr <= '0; rdPtr <= '0; fifoCount <= '0; overrun <= 1'b0; end
    else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop) fifoCount <= fifoCount + 1'b1;
      else if (doPop && !doPush) fifoCount <= fifoCount - 1'b1;
      if (pushReq && fifoFull) overrun <= 1'b1;
      else if (stb.clrOvr) overrun <= 1'b0;
    end
  end

  // R9: occupancy bounded by depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= (AW+1)'(DEPTH));
  // R10: byte completed into a full FIFO is dropped and flagged
  p_drop_when_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && fifoFull && !stb.popReq) |=> ($stable(fifoCount) && overrun));
  // R10: overrun stays until cleared
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !stb.clrOvr) |=> overrun);
  // R6: samples are only taken during reception
  p_bits_when_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBit |-> stb.running);
endmodule

// File: rtl/irRxSampler.sv
module irRxSampler
  import irRxPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16,
  parameter int CODE_W = 5,
  parameter int GAP_W  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irInN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  rxStrobes_t       stb;
  logic             rawLvl, carrierEvt, fifoFull, fifoEmpty, overrun;
  logic [7:0]       fifoHead;
  logic [CNT_W-1:0] fifoCount;
  logic [GAP_W-1:0] gapLimit;

  irRxCtrl #(.DIV_W(DIV_W), .CODE_W(CODE_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) uCtrl (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .regRdData,
    .rawLvl, .carrierEvt, .fifoHead, .fifoCount, .fifoFull, .fifoEmpty,
    .overrun, .gapLimit, .stb);

  irRxDatapath #(.DEPTH(DEPTH), .GAP_W(GAP_W), .BITS(8)) uData (
    .clk, .rstN, .irInN, .stb, .gapLimit, .rawLvl, .carrierEvt, .fifoHead,
    .fifoCount, .fifoFull, .fifoEmpty, .overrun);
endmodule

// File: tb/tb_irRxSampler.sv
module tb_irRxSampler;
  logic clk = 1'b0, rstN = 1'b0, irInN = 1'b1;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  irRxSampler dut (.clk, .rstN, .irInN, .regWrEn, .regRdEn, .regAddr,
                   .regWrData, .regRdData);

  always #5 clk = ~clk;

  // {7'b0, demod, carrier cfg, divisor low, pattern}; pattern bit 0 is 0
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {7'd0, 1'b0, 8'h00, 8'd15, 8'h5A},
    {7'd0, 1'b0, 8'h00, 8'd15, 8'hA4},
    {7'd0, 1'b0, 8'h00, 8'd15, 8'h00},
    {7'd0, 1'b1, 8'h27, 8'd31, 8'h3C},
    {7'd0, 1'b1, 8'h00, 8'd31, 8'h96},
    {7'd0, 1'b1, 8'h27, 8'd31, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FIFO %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic sendRaw(input logic [7:0] pat, input int per);
    for (int k = 0; k < 8; k++) begin
      irInN = pat[k];
      repeat (per) @(negedge clk);
    end
    irInN = 1'b1;
  endtask

  task automatic sendDemod(input logic [7:0] pat, input int per);
    for (int k = 0; k < 8; k++) begin
      for (int o = 0; o < per; o++) begin
        if (!pat[k] && ((k == 0 && o < 8) || (o >= 12 && o <= 29)))
          irInN = (o % 4) >= 2;
        else
          irInN = 1'b1;
        @(negedge clk);
      end
    end
    irInN = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    rdChk(3'd1, 8'h00, "R11 ctrl");
    rdChk(3'd2, 8'h00, "R11 divlo");
    rdChk(3'd3, 8'h00, "R11 divhi");
    rdChk(3'd4, 8'h00, "R11 carrier");
    rdChk(3'd5, 8'h00, "R11 status");
    rdChk(3'd0, 8'h00, "R11 data empty");

    // R4 divisor readback
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    rdChk(3'd2, 8'h34, "R4 divlo");
    rdChk(3'd3, 8'h12, "R4 divhi");
    wr(3'd3, 8'h00);

    // R1 disabled: low line has no effect
    wr(3'd2, 8'd15);
    irInN = 1'b0; repeat (150) @(negedge clk); irInN = 1'b1;
    rdChk(3'd1, 8'h00, "R1 no activity");
    rdChk(3'd5, 8'h00, "R1 fifo empty");

    // vector walk: R2 R3 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      logic dm;
      logic [7:0] pat;
      dm  = VEC[i][24];
      pat = VEC[i][7:0];
      wr(3'd4, VEC[i][23:16]);
      wr(3'd2, VEC[i][15:8]);
      wr(3'd1, {6'd0, dm, 1'b1});
      if (dm) sendDemod(pat, 32); else sendRaw(pat, 16);
      rdChk(3'd1, {5'd0, 1'b1, dm, 1'b1}, "R6 active flag");
      repeat (dm ? 12 : 1) @(negedge clk);
      wr(3'd1, {5'd0, 1'b1, dm, 1'b1});
      rdChk(3'd5, 8'h09, dm ? "R3 one byte" : "R2 one byte");
      rdChk(3'd0, pat, dm ? "R3 R8 demod byte" : "R2 R8 raw byte");
      rdChk(3'd5, 8'h00, "R9 drained");
      repeat (20) @(negedge clk);
    end

    // R5 tight gap limit: carrier with spacing 4 not detected
    wr(3'd4, 8'h21); wr(3'd2, 8'd31); wr(3'd1, 8'h03);
    for (int o = 0; o < 200; o++) begin irInN = (o % 4) >= 2; @(negedge clk); end
    irInN = 1'b1;
    rdChk(3'd1, 8'h03, "R5 no carrier");
    rdChk(3'd5, 8'h00, "R5 fifo empty");
    wr(3'd1, 8'h00);

    // R7 stop discards partial byte, restart at bit 0
    wr(3'd2, 8'd15); wr(3'd1, 8'h01);
    irInN = 1'b0; repeat (40) @(negedge clk); irInN = 1'b1;
    repeat (8) @(negedge clk);
    wr(3'd1, 8'h05);
    rdChk(3'd1, 8'h01, "R7 flag cleared");
    repeat (20) @(negedge clk);
    sendRaw(8'hA4, 16);
    wr(3'd1, 8'h05);
    rdChk(3'd5, 8'h09, "R7 one byte");
    rdChk(3'd0, 8'hA4, "R7 restart byte");

    // R10 overrun, R1 enable clear, R9 full
    wr(3'd2, 8'd3); wr(3'd1, 8'h01);
    irInN = 1'b0; repeat (700) @(negedge clk);
    wr(3'd1, 8'h00);
    irInN = 1'b1;
    rdChk(3'd1, 8'h00, "R1 enable clear drops flag");
    rdChk(3'd5, 8'h87, "R10 full with overrun");
    for (int j = 0; j < 16; j++) begin
      rd(3'd0, v);
      check("R9 fifo byte", v, 8'h00);
    end
    rdChk(3'd5, 8'h04, "R10 sticky after drain");
    wr(3'd5, 8'h04);
    rdChk(3'd5, 8'h00, "R10 cleared");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule